// File: doc/BRIEF.md
# NCO Hop-Update Controller

This block retunes a numerically controlled oscillator without disturbing it. A hop request carries a new 48-bit frequency word, an 18-bit phase offset and a two-bit field mask. Once accepted, the selected fields are cut into 16-bit words. Each word is written into a shadow register bank as its own internal write, and each write occupies a fixed five-cycle slot. While the writes run, `busy` is high and the oscillator keeps running on the settings it already had. On the clock edge where `busy` falls, every field named in the mask moves from the shadow bank into the active registers at the same moment. A one-cycle `commit` pulse then marks the first sample clock that uses the new settings.

The phase accumulator adds the active frequency word on every clock. The output phase is the top 16 bits of the accumulator plus the active phase offset, with the offset aligned to the accumulator's most significant bits. No request is taken until the startup-done input is high. A full update takes 25 cycles, which is 125 ns at 200 MHz, so a hop rate of one per microsecond leaves plenty of margin.

The request side follows valid/ready rules. `req_ready` is high only while `startup_done` is high and `busy` is low. A beat is taken on an edge where both `req_valid` and `req_ready` are high. A source may hold `req_valid` for as long as it likes while `startup_done` is low. Presenting `req_valid` while `busy` is high is a protocol violation. That beat is dropped, and the violation is recorded in a sticky error flag.

Top module: `nco_hop_ctrl`

## Requirements
- R1: After reset, `busy`, `commit` and `err` are 0, and the active frequency and phase are both zero, so `phase_out` stays 0 for as long as no request is accepted.
- R2: `req_ready` is 1 exactly when `startup_done` is 1 and `busy` is 0. A request held while `startup_done` is 0 is not taken, and `busy` stays low.
- R3: The mask fields are: bit 0 selects the frequency (three 16-bit writes, least significant word first) and bit 1 selects the phase (two 16-bit writes, low word first). `busy` rises in the cycle after acceptance and stays high for exactly 5 × (number of writes) cycles: 15, 10 or 25.
- R4: A request with mask 00 is accepted but starts no writes. `busy` and `commit` stay low, and the oscillator output is unchanged.
- R5: While `busy` is high, `phase_out` continues exactly as if no request had been made, using the previously active frequency and phase.
- R6: Every masked field takes its new value on the edge where `busy` falls, and all of them change together. Fields outside the mask keep their values. `commit` is high for exactly one cycle, which is the first cycle with `busy` low.
- R7: A 48-bit accumulator wraps modulo 2^48 and adds the active frequency on every clock. `phase_out` is bits 47:32 of (accumulator + phase × 2^30) mod 2^48.
- R8: A request presented while `busy` is high is not taken and does not alter the update in progress. It sets `err`, which stays high until `err_clr` is seen. When a violation and `err_clr` occur in the same cycle, `err` is set.
- R9: A new request is accepted in the `commit` cycle itself, so back-to-back full hops take 26 cycles each. That is well under the 200 cycles of a microsecond at 200 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample and control clock |
| rst | input | 1 | Synchronous active-high reset |
| startup_done | input | 1 | High once the startup sequence has finished |
| err_clr | input | 1 | Clears the sticky protocol error |
| req_valid | input | 1 | Hop request valid |
| req_ready | output | 1 | Hop request can be taken this cycle |
| req_freq | input | 48 | New frequency word |
| req_phase | input | 18 | New phase offset |
| req_mask | input | 2 | Bit 0 frequency, bit 1 phase |
| busy | output | 1 | Register writes in progress |
| commit | output | 1 | One-cycle pulse: new settings are in use |
| err | output | 1 | Sticky flag: request seen while busy |
| phase_out | output | 16 | Oscillator phase word |

## Verification
The hardest case to reach from the ports is a violating request that lands in the very last busy cycle, on the same edge that commits the update. Sometimes `err_clr` arrives in that same cycle as well. The bench counts busy cycles from the acceptance edge and raises `req_valid` exactly in slot 5·n−1, with `err_clr` either off or on. A cycle-accurate arithmetic model of the accumulator then confirms that neither the committed values nor the commit timing moved.

// File: rtl/nco_hop_pkg.sv
`timescale 1ns/1ps
package nco_hop_pkg;
  // mask bit positions on the request
  localparam int unsigned MASK_FREQ  = 0;
  localparam int unsigned MASK_PHASE = 1;

  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_WRITE = 1'b1
  } seq_state_e;

  function automatic int unsigned bits_for(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  function automatic int unsigned words_for(input int unsigned bits, input int unsigned word);
    return (bits + word - 1) / word;
  endfunction
endpackage

// File: rtl/hop_req_port.sv
`timescale 1ns/1ps
module hop_req_port #(
  parameter int unsigned FREQ_W  = 48,
  parameter int unsigned PHASE_W = 18
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               startup_done,
  input  logic               err_clr,
  input  logic               req_valid,
  input  logic [FREQ_W-1:0]  req_freq,
  input  logic [PHASE_W-1:0] req_phase,
  input  logic [1:0]         req_mask,
  input  logic               busy,
  output logic               req_ready,
  output logic               accept,
  output logic [FREQ_W-1:0]  lat_freq,
  output logic [PHASE_W-1:0] lat_phase,
  output logic [1:0]         lat_mask,
  output logic               err
);
  assign req_ready = startup_done && !busy;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_freq  <= '0;
      lat_phase <= '0;
      lat_mask  <= '0;
    end else if (accept) begin
      lat_freq  <= req_freq;
      lat_phase <= req_phase;
      lat_mask  <= req_mask;
    end
  end

  // sticky violation flag, set has priority over clear
  always_ff @(posedge clk) begin
    if (rst)                    err <= 1'b0;
    else if (req_valid && busy) err <= 1'b1;
    else if (err_clr)           err <= 1'b0;
  end
endmodule

// File: rtl/hop_write_seq.sv
`timescale 1ns/1ps
module hop_write_seq
  import nco_hop_pkg::*;
#(
  parameter int unsigned FREQ_WORDS   = 3,
  parameter int unsigned PHASE_WORDS  = 2,
  parameter int unsigned WRITE_CYCLES = 5,
  parameter int unsigned IDX_W        = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic [1:0]       mask,
  output logic             busy,
  output logic             wr_en,
  output logic             wr_last,
  output logic [IDX_W-1:0] wr_idx,
  output logic             commit
);
  localparam int unsigned TOTAL = FREQ_WORDS + PHASE_WORDS;
  localparam int unsigned CYC_W = bits_for(WRITE_CYCLES);

  seq_state_e       st_q;
  logic [CYC_W-1:0] cyc_q;
  logic [IDX_W-1:0] idx_q, last_q;
  logic [IDX_W-1:0] first_c, last_c;
  logic             slot_end;

  assign first_c  = mask[MASK_FREQ]  ? '0 : IDX_W'(FREQ_WORDS);
  assign last_c   = mask[MASK_PHASE] ? IDX_W'(TOTAL - 1) : IDX_W'(FREQ_WORDS - 1);
  assign slot_end = (st_q == SEQ_WRITE) && (cyc_q == CYC_W'(WRITE_CYCLES - 1));

  assign busy    = (st_q == SEQ_WRITE);
  assign wr_en   = slot_end;
  assign wr_last = slot_end && (idx_q == last_q);
  assign wr_idx  = idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SEQ_IDLE;
      cyc_q  <= '0;
      idx_q  <= '0;
      last_q <= '0;
      commit <= 1'b0;
    end else begin
      commit <= 1'b0;
      case (st_q)
        SEQ_IDLE: begin
          if (accept && (|mask)) begin
            st_q   <= SEQ_WRITE;
            cyc_q  <= '0;
            idx_q  <= first_c;
            last_q <= last_c;
          end
        end
        SEQ_WRITE: begin
          if (slot_end) begin
            cyc_q <= '0;
            if (idx_q == last_q) begin
              st_q   <= SEQ_IDLE;
              commit <= 1'b1;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end else begin
            cyc_q <= cyc_q + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/hop_shadow_regs.sv
`timescale 1ns/1ps
module hop_shadow_regs
  import nco_hop_pkg::*;
#(
  parameter int unsigned FREQ_W      = 48,
  parameter int unsigned PHASE_W     = 18,
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned FREQ_WORDS  = 3,
  parameter int unsigned PHASE_WORDS = 2,
  parameter int unsigned IDX_W       = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FREQ_W-1:0]  lat_freq,
  input  logic [PHASE_W-1:0] lat_phase,
  input  logic [1:0]         lat_mask,
  input  logic               wr_en,
  input  logic               wr_last,
  input  logic [IDX_W-1:0]   wr_idx,
  output logic [FREQ_W-1:0]  act_freq,
  output logic [PHASE_W-1:0] act_phase
);
  localparam int unsigned TOTAL  = FREQ_WORDS + PHASE_WORDS;
  localparam int unsigned FPAD_W = FREQ_WORDS * WORD_W;
  localparam int unsigned PPAD_W = PHASE_WORDS * WORD_W;

  logic [FPAD_W-1:0]       f_ext;
  logic [PPAD_W-1:0]       p_ext;
  logic [WORD_W-1:0]       src_w [TOTAL];
  logic [WORD_W-1:0]       sh_q  [TOTAL];
  logic [WORD_W-1:0]       sh_n  [TOTAL];
  logic [TOTAL*WORD_W-1:0] sh_flat;

  assign f_ext = FPAD_W'(lat_freq);
  assign p_ext = PPAD_W'(lat_phase);

  // source words: frequency low word first, then phase low word first
  for (genvar i = 0; i < FREQ_WORDS; i++) begin : g_fsrc
    assign src_w[i] = f_ext[i*WORD_W +: WORD_W];
  end
  for (genvar j = 0; j < PHASE_WORDS; j++) begin : g_psrc
    assign src_w[FREQ_WORDS+j] = p_ext[j*WORD_W +: WORD_W];
  end

  // next shadow contents including the write that lands this cycle
  for (genvar k = 0; k < TOTAL; k++) begin : g_shadow
    assign sh_n[k] = (wr_en && (wr_idx == IDX_W'(k))) ? src_w[k] : sh_q[k];
    assign sh_flat[k*WORD_W +: WORD_W] = sh_n[k];
  end

  if (FPAD_W > FREQ_W) begin : g_fpad
    logic unused_fpad;
    assign unused_fpad = ^sh_flat[FPAD_W-1:FREQ_W];
  end
  if (PPAD_W > PHASE_W) begin : g_ppad
    logic unused_ppad;
    assign unused_ppad = ^sh_flat[TOTAL*WORD_W-1:FPAD_W+PHASE_W];
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < TOTAL; i++) begin
      if (rst) sh_q[i] <= '0;
      else     sh_q[i] <= sh_n[i];
    end
  end

  // atomic switch-over on the final write of the update
  always_ff @(posedge clk) begin
    if (rst) begin
      act_freq  <= '0;
      act_phase <= '0;
    end else if (wr_last) begin
      if (lat_mask[MASK_FREQ])  act_freq  <= sh_flat[FREQ_W-1:0];
      if (lat_mask[MASK_PHASE]) act_phase <= sh_flat[FPAD_W +: PHASE_W];
    end
  end
endmodule

// File: rtl/nco_phase_acc.sv
`timescale 1ns/1ps
module nco_phase_acc #(
  parameter int unsigned FREQ_W  = 48,
  parameter int unsigned PHASE_W = 18,
  parameter int unsigned OUT_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FREQ_W-1:0]  freq,
  input  logic [PHASE_W-1:0] phase,
  output logic [OUT_W-1:0]   phase_out
);
  localparam int unsigned SHIFT = FREQ_W - PHASE_W;

  logic [FREQ_W-1:0] acc_q;
  logic [FREQ_W-1:0] sum;

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_q + freq;
  end

  assign sum       = acc_q + (FREQ_W'(phase) << SHIFT);
  assign phase_out = sum[FREQ_W-1 -: OUT_W];
endmodule

// File: rtl/nco_hop_ctrl.sv
`timescale 1ns/1ps
module nco_hop_ctrl
  import nco_hop_pkg::*;
#(
  parameter int unsigned FREQ_W       = 48,
  parameter int unsigned PHASE_W      = 18,
  parameter int unsigned WORD_W       = 16,
  parameter int unsigned WRITE_CYCLES = 5,
  parameter int unsigned OUT_W        = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               startup_done,
  input  logic               err_clr,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [FREQ_W-1:0]  req_freq,
  input  logic [PHASE_W-1:0] req_phase,
  input  logic [1:0]         req_mask,
  output logic               busy,
  output logic               commit,
  output logic               err,
  output logic [OUT_W-1:0]   phase_out
);
  localparam int unsigned FREQ_WORDS  = words_for(FREQ_W, WORD_W);
  localparam int unsigned PHASE_WORDS = words_for(PHASE_W, WORD_W);
  localparam int unsigned IDX_W       = bits_for(FREQ_WORDS + PHASE_WORDS);

  logic               accept;
  logic [FREQ_W-1:0]  lat_freq;
  logic [PHASE_W-1:0] lat_phase;
  logic [1:0]         lat_mask;
  logic               wr_en, wr_last;
  logic [IDX_W-1:0]   wr_idx;
  logic [FREQ_W-1:0]  act_freq;
  logic [PHASE_W-1:0] act_phase;

  hop_req_port #(.FREQ_W(FREQ_W), .PHASE_W(PHASE_W)) u_req (
    .clk(clk), .rst(rst), .startup_done(startup_done), .err_clr(err_clr),
    .req_valid(req_valid), .req_freq(req_freq), .req_phase(req_phase),
    .req_mask(req_mask), .busy(busy), .req_ready(req_ready), .accept(accept),
    .lat_freq(lat_freq), .lat_phase(lat_phase), .lat_mask(lat_mask), .err(err)
  );

  hop_write_seq #(
    .FREQ_WORDS(FREQ_WORDS), .PHASE_WORDS(PHASE_WORDS),
    .WRITE_CYCLES(WRITE_CYCLES), .IDX_W(IDX_W)
  ) u_seq (
    .clk(clk), .rst(rst), .accept(accept), .mask(req_mask), .busy(busy),
    .wr_en(wr_en), .wr_last(wr_last), .wr_idx(wr_idx), .commit(commit)
  );

  hop_shadow_regs #(
    .FREQ_W(FREQ_W), .PHASE_W(PHASE_W), .WORD_W(WORD_W),
    .FREQ_WORDS(FREQ_WORDS), .PHASE_WORDS(PHASE_WORDS), .IDX_W(IDX_W)
  ) u_regs (
    .clk(clk), .rst(rst), .lat_freq(lat_freq), .lat_phase(lat_phase),
    .lat_mask(lat_mask), .wr_en(wr_en), .wr_last(wr_last), .wr_idx(wr_idx),
    .act_freq(act_freq), .act_phase(act_phase)
  );

  nco_phase_acc #(.FREQ_W(FREQ_W), .PHASE_W(PHASE_W), .OUT_W(OUT_W)) u_nco (
    .clk(clk), .rst(rst), .freq(act_freq), .phase(act_phase), .phase_out(phase_out)
  );
endmodule

// File: rtl/nco_hop_chk.sv
`timescale 1ns/1ps
module nco_hop_chk
  import nco_hop_pkg::*;
#(
  parameter int unsigned FREQ_W       = 48,
  parameter int unsigned PHASE_W      = 18,
  parameter int unsigned WRITE_CYCLES = 5,
  parameter int unsigned FREQ_WORDS   = 3,
  parameter int unsigned PHASE_WORDS  = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               startup_done,
  input logic               err_clr,
  input logic               req_valid,
  input logic               req_ready,
  input logic [1:0]         req_mask,
  input logic               busy,
  input logic               commit,
  input logic               err,
  input logic [FREQ_W-1:0]  act_freq,
  input logic [PHASE_W-1:0] act_phase
);
  localparam int unsigned CNT_W = bits_for((FREQ_WORDS + PHASE_WORDS) * WRITE_CYCLES + 2);

  logic [CNT_W-1:0] bcnt;
  always_ff @(posedge clk) begin
    if (rst)       bcnt <= '0;
    else if (busy) bcnt <= bcnt + 1'b1;
    else           bcnt <= '0;
  end

  a_r2_startup_gate: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(startup_done) && $past(req_valid)));

  a_r3_busy_length: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (bcnt == CNT_W'(FREQ_WORDS * WRITE_CYCLES) ||
                     bcnt == CNT_W'(PHASE_WORDS * WRITE_CYCLES) ||
                     bcnt == CNT_W'((FREQ_WORDS + PHASE_WORDS) * WRITE_CYCLES)));

  a_r4_empty_mask: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_mask == 2'b00) |=> !busy);

  a_r5_hold_active: assert property (@(posedge clk) disable iff (rst)
    busy |-> ($stable(act_freq) && $stable(act_phase)));

  a_r6_commit_on_fall: assert property (@(posedge clk) disable iff (rst)
    commit |-> $fell(busy));

  a_r6_fall_gives_commit: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> commit);

  a_r8_err_set: assert property (@(posedge clk) disable iff (rst)
    (req_valid && busy) |=> err);

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (err && !err_clr) |=> err);
endmodule

bind nco_hop_ctrl nco_hop_chk #(
  .FREQ_W(FREQ_W), .PHASE_W(PHASE_W), .WRITE_CYCLES(WRITE_CYCLES),
  .FREQ_WORDS(FREQ_WORDS), .PHASE_WORDS(PHASE_WORDS)
) u_chk (
  .clk(clk), .rst(rst), .startup_done(startup_done), .err_clr(err_clr),
  .req_valid(req_valid), .req_ready(req_ready), .req_mask(req_mask),
  .busy(busy), .commit(commit), .err(err),
  .act_freq(act_freq), .act_phase(act_phase)
);

// File: tb/sim_nco_hop_ctrl.sv
`timescale 1ns/1ps
module sim_nco_hop_ctrl;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst, startup_done, err_clr, req_valid;
  logic        req_ready, busy, commit, err;
  logic [47:0] req_freq;
  logic [17:0] req_phase;
  logic [1:0]  req_mask;
  logic [15:0] phase_out;

  nco_hop_ctrl u0 (
    .clk(clk), .rst(rst), .startup_done(startup_done), .err_clr(err_clr),
    .req_valid(req_valid), .req_ready(req_ready), .req_freq(req_freq),
    .req_phase(req_phase), .req_mask(req_mask), .busy(busy), .commit(commit),
    .err(err), .phase_out(phase_out)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit run_chk = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int nw(input logic [1:0] m);
    return (m[0] ? 3 : 0) + (m[1] ? 2 : 0);
  endfunction

  // arithmetic reference model
  logic        m_busy, m_commit, m_err;
  int          m_cnt;
  logic [47:0] m_acc, m_f, m_pf;
  logic [17:0] m_p, m_pp;
  logic [1:0]  m_pm;
  logic [47:0] m_sum;
  assign m_sum = m_acc + {m_p, 30'd0};

  always @(posedge clk) begin
    if (rst) begin
      m_busy <= 0; m_commit <= 0; m_err <= 0; m_cnt <= 0;
      m_acc <= '0; m_f <= '0; m_p <= '0; m_pf <= '0; m_pp <= '0; m_pm <= '0;
    end else begin
      m_acc    <= m_acc + m_f;
      m_commit <= 1'b0;
      if (m_busy) begin
        if (m_cnt == 1) begin
          m_busy   <= 1'b0;
          m_commit <= 1'b1;
          if (m_pm[0]) m_f <= m_pf;
          if (m_pm[1]) m_p <= m_pp;
        end
        m_cnt <= m_cnt - 1;
      end else if (req_valid && startup_done && nw(req_mask) > 0) begin
        m_busy <= 1'b1;
        m_cnt  <= 5 * nw(req_mask);
        m_pf   <= req_freq;
        m_pp   <= req_phase;
        m_pm   <= req_mask;
      end
      if (req_valid && m_busy) m_err <= 1'b1;
      else if (err_clr)        m_err <= 1'b0;
    end
  end

  always @(negedge clk) begin
    if (!rst && run_chk) begin
      chk("R2 ready", 64'(req_ready), 64'(startup_done && !m_busy));
      chk("R3 busy", 64'(busy), 64'(m_busy));
      chk("R6 commit", 64'(commit), 64'(m_commit));
      chk("R8 err", 64'(err), 64'(m_err));
      if (m_busy) chk("R5 phase during busy", 64'(phase_out), 64'(m_sum[47:32]));
      else        chk("R7 phase", 64'(phase_out), 64'(m_sum[47:32]));
    end
  end

  // caller is at a negedge; returns at the negedge where busy is first low
  task automatic hop(input logic [1:0] m, input logic [47:0] f, input logic [17:0] p,
                     input int intr, input logic clr_at_intr, input int gap);
    int bl;
    int cm;
    int n;
    n = nw(m);
    req_mask = m; req_freq = f; req_phase = p; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    bl = 0; cm = 0;
    while (busy) begin
      if (commit) cm++;
      req_valid = (bl == intr);
      err_clr   = clr_at_intr && (bl == intr);
      bl++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    err_clr   = 1'b0;
    chk("R3 busy length", 64'(bl), 64'(5 * n));
    chk("R6 commit in first idle cycle", 64'(commit), 64'(n > 0));
    chk("R6 no commit while busy", 64'(cm), 64'd0);
    if (n == 0) chk("R4 empty mask starts nothing", 64'(bl), 64'd0);
    repeat (gap) @(negedge clk);
  endtask

  logic [47:0] fv [5];
  logic [17:0] pv [4];

  initial begin
    fv[0] = 48'h0;            fv[1] = 48'h1;
    fv[2] = 48'h8000_0000_0000; fv[3] = 48'hFFFF_FFFF_FFFF;
    fv[4] = 48'h1234_5678_9ABC;
    pv[0] = 18'h0; pv[1] = 18'h3FFFF; pv[2] = 18'h20000; pv[3] = 18'h15555;

    rst = 1'b1; startup_done = 1'b0; err_clr = 1'b0; req_valid = 1'b0;
    req_freq = '0; req_phase = '0; req_mask = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    run_chk = 1'b1;
    chk("R1 busy after reset", 64'(busy), 64'd0);
    chk("R1 commit after reset", 64'(commit), 64'd0);
    chk("R1 err after reset", 64'(err), 64'd0);
    repeat (10) @(negedge clk);
    chk("R1 phase stays zero", 64'(phase_out), 64'd0);

    // request held until startup completes
    fork
      hop(2'b11, 48'h0000_1000_0000, 18'h01000, -1, 1'b0, 3);
      begin
        repeat (20) @(negedge clk);
        chk("R2 no busy before startup", 64'(busy), 64'd0);
        chk("R2 not ready before startup", 64'(req_ready), 64'd0);
        startup_done = 1'b1;
      end
    join

    // sweep masks, frequency and phase corners
    for (int m = 0; m < 4; m++)
      for (int fi = 0; fi < 5; fi++)
        for (int pi = 0; pi < 4; pi++)
          hop(2'(m), fv[fi], pv[pi], -1, 1'b0, 1 + (fi % 3));

    // violation in the first busy cycle
    hop(2'b11, 48'h0F0F_0000_1111, 18'h00ABC, 0, 1'b0, 2);
    chk("R8 err set by early violation", 64'(err), 64'd1);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    chk("R8 err cleared", 64'(err), 64'd0);

    // violation in the last busy cycle of a frequency-only update
    hop(2'b01, 48'h0000_0400_0000, 18'h3F000, 14, 1'b0, 2);
    chk("R8 err set by late violation", 64'(err), 64'd1);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;

    // violation together with clear: set wins
    hop(2'b10, 48'h0, 18'h12345, 9, 1'b1, 2);
    chk("R8 set wins over clear", 64'(err), 64'd1);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;

    // back-to-back hops
    hop(2'b11, 48'h0000_2000_0000, 18'h04000, -1, 1'b0, 0);
    chk("R9 ready in commit cycle", 64'(req_ready && commit), 64'd1);
    hop(2'b11, 48'h0000_0800_0000, 18'h2AAAA, -1, 1'b0, 0);
    chk("R9 ready in commit cycle again", 64'(req_ready && commit), 64'd1);
    hop(2'b01, 48'h0000_0100_0000, 18'h0, -1, 1'b0, 8);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R3 watchdog actual still running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule